// File: doc/BRIEF.md
# Two-Level Address Translator with Translation Buffer

This block turns a virtual address into a physical address for a segmented-paging memory scheme. The virtual address holds a page offset and a virtual page number. The page number splits into a segment number in the upper bits and a segment offset in the lower bits. A small fully associative translation buffer is searched first. It compares every stored page number against the request in one cycle.

When the buffer holds no match, the block walks the tables through a single-outstanding memory read port. The first read uses the segment-table base input plus the segment number, and the word it returns is the base of that segment's page table. The second read uses that base plus the segment offset, and the word it returns carries the frame number. The new page-to-frame pair is then installed in the buffer, with the victim slot chosen round-robin.

The CPU side is a request/ready handshake: a request is taken when `reqValid` and `reqReady` are both high. The result comes back as a one-cycle `doneValid` pulse with `donePaddr`. Every page is assumed resident, so there is no fault path.

Top module: `xlate_translator`

## Requirements
- R1: The physical address is the frame number in the upper FRAME_W bits, concatenated with the untouched OFF_W-bit page offset (vaddr[OFF_W-1:0]) in the lower bits.
- R2: On a buffer hit, `doneValid` is high in the cycle right after the accepting clock edge, and no memory read is issued.
- R3: On a miss, the first read address is `stBase` plus the zero-extended segment number (vaddr[VA_W-1 -: SEG_W]).
- R4: The second read address is the low ADDR_W bits of the first read's data plus the zero-extended segment offset (vaddr[OFF_W +: SOFF_W]). The frame number is the low FRAME_W bits of the second read's data. A miss issues exactly two reads.
- R5: After a walk, the translated page is held in the buffer, so a repeated request for the same page hits. No two valid entries ever match the same page.
- R6: Fills go to slots in round-robin order, starting at slot 0 after reset and wrapping after slot TLB_N-1. With TLB_N=4, the fifth distinct miss evicts the page installed first.
- R7: A high `flush` at a clock edge clears every valid bit. Flush wins over a fill in the same cycle, so the next request for any page walks the tables.
- R8: `reqReady` is high only when idle. It stays low from the accepting edge through the done cycle, and `doneValid` is a single-cycle pulse.
- R9: `memReq` stays high with a stable `memAddr` until `memAck` is seen. Only one read is outstanding at a time.
- R10: After reset the buffer is empty, `reqReady` is 1, and `doneValid` and `memReq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| reqValid | input | 1 | Translation request valid |
| reqVaddr | input | VA_W | Virtual address {segment, segment offset, page offset} |
| reqReady | output | 1 | Block can accept a request |
| stBase | input | ADDR_W | Segment-table base address |
| doneValid | output | 1 | One-cycle result strobe |
| donePaddr | output | PA_W | Translated physical address |
| memReq | output | 1 | Memory read request |
| memAddr | output | ADDR_W | Memory read address |
| memAck | input | 1 | Memory read acknowledge; data valid in same cycle |
| memData | input | DATA_W | Memory read data |

## Verification
The bench plays a page stream that fills the buffer, overflows it, and then revisits both evicted and surviving pages. A design whose replacement pointer drifted would hit where a walk is due, or walk where a hit is due, and the read count shows either. Each walk's two read addresses are compared against the segment-table and page-table locations. The memory's page-table words carry junk in their upper bits, so swapped address terms or a frame taken from the wrong bits give a wrong address. Flush is tested both when idle and when held across a walk, which catches a fill that beats the flush. The ready and done timing is checked every cycle of each transaction.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchReq;     // capture the request address
    logic latchPtBase;  // capture page-table base from first read
    logic latchFrame;   // capture frame from second read
    logic fillEntry;    // install page/frame pair in the buffer
    logic pageStep;     // memory address selects page-table read
    logic useWalkFrame; // result frame comes from walk register
  } xlStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_SEGRD,
    ST_PGRD,
    ST_DONE
  } xlState_t;

endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
  parameter int VPN_W   = 6,
  parameter int FRAME_W = 8,
  parameter int TLB_N   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic [VPN_W-1:0]   lookVpn,
  output logic [FRAME_W:0]   lookBus,   // all ones = not found
  input  logic               fillEn,
  input  logic [VPN_W-1:0]   fillVpn,
  input  logic [FRAME_W-1:0] fillFrame
);
  localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TLB_N - 1);

  logic [VPN_W-1:0]   tagQ   [TLB_N];
  logic [FRAME_W-1:0] frameQ [TLB_N];
  logic [TLB_N-1:0]   validQ;
  logic [TLB_N-1:0]   hitVec;
  logic [IDX_W-1:0]   rrPtr;

  for (genvar i = 0; i < TLB_N; i++) begin : g_cmp
    assign hitVec[i] = validQ[i] && (tagQ[i] == lookVpn);
  end

  always_comb begin
    lookBus = '1;
    for (int i = 0; i < TLB_N; i++) begin
      if (hitVec[i]) lookBus = {1'b0, frameQ[i]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      rrPtr  <= '0;
    end else if (flush) begin
      validQ <= '0;
    end else if (fillEn) begin
      validQ[rrPtr] <= 1'b1;
      rrPtr         <= (rrPtr == LAST_IDX) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fillEn && !flush) begin
      tagQ[rrPtr]   <= fillVpn;
      frameQ[rrPtr] <= fillFrame;
    end
  end

  AST_TLB_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec)); // R5

  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (validQ == '0)); // R7

  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flush) |=> (validQ[$past(rrPtr)] && tagQ[$past(rrPtr)] == $past(fillVpn))); // R5

  AST_RR_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (fillEn && !flush) |=> (rrPtr != $past(rrPtr) || TLB_N == 1)); // R6

endmodule

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int SEG_W   = 2,
  parameter int SOFF_W  = 4,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int TLB_N   = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         flush,
  input  xlStrobe_t                    strb,
  input  logic [SEG_W+SOFF_W+OFF_W-1:0] reqVaddr,
  input  logic [ADDR_W-1:0]            stBase,
  input  logic [DATA_W-1:0]            memData,
  output logic                         lookHit,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [FRAME_W+OFF_W-1:0]     donePaddr
);
  localparam int VPN_W = SEG_W + SOFF_W;
  localparam int VA_W  = VPN_W + OFF_W;

  logic [VA_W-1:0]    vaQ;
  logic [ADDR_W-1:0]  ptBaseQ;
  logic [FRAME_W-1:0] frameQ;
  logic [FRAME_W:0]   lookBus;

  logic [VPN_W-1:0]  vpn;
  logic [SEG_W-1:0]  segNum;
  logic [SOFF_W-1:0] segOff;
  logic [OFF_W-1:0]  pageOff;

  assign vpn     = vaQ[VA_W-1:OFF_W];
  assign segNum  = vaQ[VA_W-1 -: SEG_W];
  assign segOff  = vaQ[OFF_W +: SOFF_W];
  assign pageOff = vaQ[OFF_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaQ     <= '0;
      ptBaseQ <= '0;
      frameQ  <= '0;
    end else begin
      if (strb.latchReq)    vaQ     <= reqVaddr;
      if (strb.latchPtBase) ptBaseQ <= memData[ADDR_W-1:0];
      if (strb.latchFrame)  frameQ  <= memData[FRAME_W-1:0];
    end
  end

  assign memAddr = strb.pageStep ? (ptBaseQ + ADDR_W'(segOff))
                                 : (stBase + ADDR_W'(segNum));

  assign lookHit   = ~lookBus[FRAME_W];
  assign donePaddr = {strb.useWalkFrame ? frameQ : lookBus[FRAME_W-1:0], pageOff};

  xlate_tlb #(
    .VPN_W  (VPN_W),
    .FRAME_W(FRAME_W),
    .TLB_N  (TLB_N)
  ) i_tlb (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .lookVpn  (vpn),
    .lookBus  (lookBus),
    .fillEn   (strb.fillEntry),
    .fillVpn  (vpn),
    .fillFrame(memData[FRAME_W-1:0])
  );

  AST_VA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchReq |=> $stable(vaQ)); // R1

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      lookHit,
  input  logic      memAck,
  output logic      reqReady,
  output logic      doneValid,
  output logic      memReq,
  output xlStrobe_t strb
);
  xlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    reqReady  = 1'b0;
    doneValid = 1'b0;
    memReq    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.latchReq = 1'b1;
          nextState     = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (lookHit) begin
          doneValid = 1'b1;
          nextState = ST_IDLE;
        end else begin
          nextState = ST_SEGRD;
        end
      end
      ST_SEGRD: begin
        memReq = 1'b1;
        if (memAck) begin
          strb.latchPtBase = 1'b1;
          nextState        = ST_PGRD;
        end
      end
      ST_PGRD: begin
        memReq        = 1'b1;
        strb.pageStep = 1'b1;
        if (memAck) begin
          strb.latchFrame = 1'b1;
          strb.fillEntry  = 1'b1;
          nextState       = ST_DONE;
        end
      end
      ST_DONE: begin
        doneValid         = 1'b1;
        strb.useWalkFrame = 1'b1;
        nextState         = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOOKUP && lookHit) |-> (doneValid && !memReq)); // R2

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq || doneValid) |-> !reqReady); // R8

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R8

endmodule

// File: rtl/xlate_translator.sv
module xlate_translator #(
  parameter int SEG_W   = 2,
  parameter int SOFF_W  = 4,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 8,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int TLB_N   = 4,
  localparam int VA_W   = SEG_W + SOFF_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flush,
  input  logic              reqValid,
  input  logic [VA_W-1:0]   reqVaddr,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] stBase,
  output logic              doneValid,
  output logic [PA_W-1:0]   donePaddr,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memData
);
  xlate_pkg::xlStrobe_t strb;
  logic lookHit;

  xlate_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .lookHit  (lookHit),
    .memAck   (memAck),
    .reqReady (reqReady),
    .doneValid(doneValid),
    .memReq   (memReq),
    .strb     (strb)
  );

  xlate_datapath #(
    .SEG_W  (SEG_W),
    .SOFF_W (SOFF_W),
    .OFF_W  (OFF_W),
    .FRAME_W(FRAME_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TLB_N  (TLB_N)
  ) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .flush    (flush),
    .strb     (strb),
    .reqVaddr (reqVaddr),
    .stBase   (stBase),
    .memData  (memData),
    .lookHit  (lookHit),
    .memAddr  (memAddr),
    .donePaddr(donePaddr)
  );

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr))); // R9

endmodule

// File: tb/test_xlate_translator.sv
`timescale 1ns/1ps
module test_xlate_translator;
  localparam int VA_W = 14;
  localparam int PA_W = 16;
  localparam logic [15:0] ST_BASE = 16'h0100;
  localparam logic [15:0] PT_BASE = 16'h2000;
  localparam int MEM_LAT = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic reqValid = 1'b0;
  logic [VA_W-1:0] reqVaddr = '0;
  logic reqReady;
  logic [15:0] stBase = ST_BASE;
  logic doneValid;
  logic [PA_W-1:0] donePaddr;
  logic memReq;
  logic [15:0] memAddr;
  logic memAck = 1'b0;
  logic [15:0] memData = '0;

  int nChecks = 0;
  int nBad = 0;
  int readCount = 0;
  logic [15:0] rdLog [256];

  always #5 clk = ~clk;

  xlate_translator i_xlate_translator (
    .clk(clk), .rstN(rstN), .flush(flush), .reqValid(reqValid),
    .reqVaddr(reqVaddr), .reqReady(reqReady), .stBase(stBase),
    .doneValid(doneValid), .donePaddr(donePaddr), .memReq(memReq),
    .memAddr(memAddr), .memAck(memAck), .memData(memData)
  );

  function automatic logic [7:0] frameFn(input int s, input int p);
    return 8'((s * 16 + p) * 7 + 3);
  endfunction

  function automatic logic [15:0] memFn(input logic [15:0] a);
    int idx;
    if (a >= ST_BASE && a < ST_BASE + 16'd4)
      return PT_BASE + (a - ST_BASE) * 16'h40;
    if (a >= PT_BASE && a < PT_BASE + 16'h100) begin
      idx = int'(a - PT_BASE);
      return {8'hC3, frameFn(idx / 64, idx % 64)};
    end
    return 16'hDEAD;
  endfunction

  // memory responder: ack with data after MEM_LAT waiting cycles
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (memReq && !memAck) begin
        if (cnt == MEM_LAT) begin
          memAck = 1'b1;
          memData = memFn(memAddr);
          rdLog[readCount % 256] = memAddr;
          readCount++;
          cnt = 0;
        end else cnt++;
      end else begin
        memAck = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic runXlate(input int s, input int p, input int o, input bit expHit, input string rq);
    int reads0;
    int cyc;
    bit done;
    logic [15:0] pa;
    logic [15:0] expPa;
    @(negedge clk);
    chk(reqReady === 1'b1, {rq, " R8 ready when idle"}, reqReady, 1);
    reqValid = 1'b1;
    reqVaddr = {2'(s), 4'(p), 8'(o)};
    reads0 = readCount;
    @(posedge clk);
    #1 reqValid = 1'b0;
    cyc = 0; done = 0; pa = '0;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (reqReady !== 1'b0) chk(0, {rq, " R8 ready low while busy"}, reqReady, 0);
      if (doneValid === 1'b1) begin
        done = 1;
        pa = donePaddr;
      end
    end
    chk(done, {rq, " R8 done seen"}, done, 1);
    expPa = {frameFn(s, p), 8'(o)};
    chk(pa === expPa, {rq, " R1 physical address"}, pa, expPa);
    if (expHit) begin
      chk(cyc == 1, {rq, " R2 hit latency"}, cyc, 1);
      chk(readCount == reads0, {rq, " R2 no read on hit"}, readCount - reads0, 0);
    end else begin
      chk(readCount == reads0 + 2, {rq, " R4 two reads on miss"}, readCount - reads0, 2);
      chk(rdLog[reads0 % 256] === ST_BASE + 16'(s), {rq, " R3 segment table address"},
          rdLog[reads0 % 256], ST_BASE + 16'(s));
      chk(rdLog[(reads0 + 1) % 256] === PT_BASE + 16'(s) * 16'h40 + 16'(p),
          {rq, " R4 page table address"}, rdLog[(reads0 + 1) % 256],
          PT_BASE + 16'(s) * 16'h40 + 16'(p));
    end
    @(negedge clk);
    chk(doneValid === 1'b0, {rq, " R8 done is one pulse"}, doneValid, 0);
  endtask

  // {seg, segOffset, pageOffset, expectHit}; TLB_N=4 round-robin
  // R5 repeats hit, R6 fifth distinct miss evicts the oldest slot
  localparam logic [14:0] VEC [12] = '{
    {2'd0, 4'd1,  8'h3C, 1'b0},
    {2'd0, 4'd1,  8'hF0, 1'b1},
    {2'd1, 4'd2,  8'h00, 1'b0},
    {2'd2, 4'd3,  8'hFF, 1'b0},
    {2'd3, 4'd15, 8'h81, 1'b0},
    {2'd1, 4'd2,  8'h7E, 1'b1},
    {2'd0, 4'd5,  8'h11, 1'b0},
    {2'd0, 4'd1,  8'h22, 1'b0},
    {2'd2, 4'd3,  8'h33, 1'b1},
    {2'd1, 4'd2,  8'h44, 1'b0},
    {2'd3, 4'd15, 8'h55, 1'b1},
    {2'd0, 4'd5,  8'h66, 1'b1}
  };

  initial begin
    #2000000;
    nChecks++;
    nBad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady === 1'b1, "R10 reset ready", reqReady, 1);
    chk(doneValid === 1'b0, "R10 reset done low", doneValid, 0);
    chk(memReq === 1'b0, "R10 reset no read", memReq, 0);

    for (int i = 0; i < 12; i++) begin
      runXlate(int'(VEC[i][14:13]), int'(VEC[i][12:9]), int'(VEC[i][8:1]), VEC[i][0],
               $sformatf("R5 R6 vector %0d", i));
    end

    // R7: idle flush empties the buffer
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    runXlate(0, 5, 8'h77, 1'b0, "R7 miss after flush");
    runXlate(0, 5, 8'h78, 1'b1, "R7 refill hits");

    // R7: flush held through a walk beats the fill
    @(negedge clk);
    flush = 1'b1;
    runXlate(3, 0, 8'h09, 1'b0, "R7 walk under flush");
    flush = 1'b0;
    runXlate(3, 0, 8'h0A, 1'b0, "R7 flush wins over fill");
    runXlate(3, 0, 8'h0B, 1'b1, "R7 later fill hits");

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule